// File: doc/BRIEF.md
# Smart Card Half-Duplex UART

This block moves 8-bit characters over one shared, open-drain data line to and from a smart card or SIM. It never drives the line high. It either pulls the line low or lets it float, and it reads the line back through a synchronizer. Each character on the line is a low start bit, eight data bits, an even parity bit, and then a guard period in which the line floats high. A host loads bytes to send and collects received bytes through valid/ready handshakes. An external tick, 16 per bit by default, sets the bit rate.

There are two bit conventions. In direct mode the data goes out least significant bit first, at true levels. In inverse mode it goes out most significant bit first with every bit inverted. When error signalling is enabled, a receiver that finds bad parity pulls the line low in the guard period to tell the sender. In the same mode the transmitter raises its completion pulse only after it has checked that period for such a pulse. Transmit and receive share one state machine, because only one of them can own the line at a time.

Top module: `sc_uart`

## Requirements
- R1: A transmitted frame is a low start bit, eight data bits and a parity bit, each OVS ticks long. After the parity bit the block releases the line (`line_drive_low` = 0).
- R2: With `cfg_inverse` = 0, data bits go out in the order bit 0 to bit 7 at true levels. The parity bit is the XOR of the byte, which makes the parity even.
- R3: With `cfg_inverse` = 1, data bits go out in the order bit 7 to bit 0, each inverted. The parity bit is also inverted on the line.
- R4: A received character is decoded under the selected convention. `rx_data` is the logical byte. `rx_perr` is 1 when the logical parity bit differs from the XOR of the logical byte.
- R5: With `cfg_err_en` = 1, a received character with bad parity makes the block pull the line low. The pulse starts OVS/2 ticks after the parity bit ends and lasts ERR_TICKS ticks.
- R6: With `cfg_err_en` = 0, the block never drives the line while receiving, even on a parity error. Only `rx_perr` reports the error.
- R7: With `cfg_err_en` = 0, `tx_done` pulses at the end of the last data bit, 9×OVS ticks after the start bit begins, with `tx_err` = 0.
- R8: With `cfg_err_en` = 1, `tx_done` pulses in the middle of the error-signal window, 10×OVS + OVS/2 + ERR_TICKS/2 ticks after the start bit begins. `tx_err` is set to 1 if the line is low at that point and to 0 otherwise.
- R9: A low on the line shorter than half a bit is not taken as a start bit. No character is reported, and the block returns to idle.
- R10: `tx_ready` is 0 while a character is being received or sent. A transmit request made during reception is refused and does not drive the line.
- R11: `rx_valid` stays high with `rx_data` stable until the host asserts `rx_ready`.
- R12: After reset the line is released, `tx_ready` = 1, and `rx_valid` = 0 and `tx_done` = 0.
- R13: `tx_done` is high for exactly one clock cycle per character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Bit-rate tick, OVS per bit |
| cfg_inverse | input | 1 | 1 = inverse convention, 0 = direct |
| cfg_err_en | input | 1 | 1 = error signalling on |
| tx_valid | input | 1 | Host offers a byte to send |
| tx_ready | output | 1 | Block accepts a byte (idle, line high) |
| tx_data | input | DATA_W | Byte to send |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Host takes the received byte |
| rx_data | output | DATA_W | Received logical byte |
| rx_perr | output | 1 | Parity error on the received byte |
| tx_done | output | 1 | One-cycle transmit completion pulse |
| tx_err | output | 1 | Card signalled an error on the last sent byte |
| line_in | input | 1 | Sensed level of the shared line |
| line_drive_low | output | 1 | 1 = pull the shared line low |

## Verification
The bench builds the block with OVS = 8 and ERR_TICKS = 12, and pulses the tick every second clock. A full frame, including its guard period, then takes about 200 clocks. That lets one short run cover both conventions, both error-signalling settings, clean and corrupted parity in both directions, a short glitch, and a transmit request made during reception. Because ERR_TICKS is 12 rather than a multiple of the bit time, the window measurements show whether the error-window and sampling-point arithmetic is right.

// File: rtl/sc_uart_pkg.sv
package sc_uart_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX_START,
    ST_RX_BIT,
    ST_TX_BIT,
    ST_GUARD
  } sc_state_e;
endpackage

// File: rtl/sc_line_sync.sv
// Synchronizer for the shared line; resets to the released (high) level.
module sc_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/sc_char_codec.sv
// Maps logical bytes to line bit patterns and back, for both conventions.
module sc_char_codec #(
  parameter int DATA_W = 8
) (
  input  logic              inverse,
  input  logic [DATA_W-1:0] tx_byte,
  output logic [DATA_W:0]   tx_line,
  input  logic [DATA_W:0]   rx_line,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_par_bad
);
  logic rx_par_logic;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign tx_line[i] = inverse ? ~tx_byte[DATA_W-1-i] : tx_byte[i];
    assign rx_byte[i] = inverse ? ~rx_line[DATA_W-1-i] : rx_line[i];
  end

  assign tx_line[DATA_W] = inverse ? ~(^tx_byte) : (^tx_byte);
  assign rx_par_logic    = inverse ? ~rx_line[DATA_W] : rx_line[DATA_W];
  assign rx_par_bad      = (^rx_byte) ^ rx_par_logic;
endmodule

// File: rtl/sc_frame_ctrl.sv
// Shared transmit/receive sequencer for the single data line.
module sc_frame_ctrl
  import sc_uart_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int OVS       = 16,
  parameter int ERR_TICKS = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            line_s,
  input  logic            err_en,
  input  logic            tx_req,
  input  logic [DATA_W:0] tx_pattern,
  output logic            tx_ready,
  output logic [DATA_W:0] line_bits,
  input  logic            rx_par_bad,
  output logic            rx_end,
  output logic            tx_done,
  output logic            tx_err,
  output logic            drive_low,
  output logic            tx_active
);
  localparam int NBIT      = DATA_W + 1;
  localparam int HALF      = OVS / 2;
  localparam int WIN_START = OVS;
  localparam int WIN_END   = OVS + ERR_TICKS;
  localparam int WIN_MID   = OVS + ERR_TICKS / 2;
  localparam int GUARD_END = WIN_END + HALF;
  localparam int TC_W      = $clog2(OVS);
  localparam int BN_W      = $clog2(NBIT + 1);
  localparam int G_W       = $clog2(GUARD_END + 1);

  localparam logic [TC_W-1:0] TC_LAST  = TC_W'(OVS - 1);
  localparam logic [TC_W-1:0] TC_MID   = TC_W'(HALF - 1);
  localparam logic [BN_W-1:0] BN_PAR   = BN_W'(NBIT);
  localparam logic [BN_W-1:0] BN_LASTD = BN_W'(DATA_W);
  localparam logic [BN_W-1:0] BN_D0    = BN_W'(1);
  localparam logic [G_W-1:0]  G_HALF   = G_W'(HALF);
  localparam logic [G_W-1:0]  G_WSTART = G_W'(WIN_START);
  localparam logic [G_W-1:0]  G_WEND   = G_W'(WIN_END);
  localparam logic [G_W-1:0]  G_SAMP   = G_W'(WIN_MID - 1);
  localparam logic [G_W-1:0]  G_LAST   = G_W'(GUARD_END - 1);

  sc_state_e       state;
  logic [TC_W-1:0] tc;
  logic [BN_W-1:0] bitn;
  logic [G_W-1:0]  g;
  logic [NBIT-1:0] shreg;
  logic            is_tx;
  logic            drive_nxt;

  always_comb begin
    drive_nxt = 1'b0;
    case (state)
      ST_TX_BIT: drive_nxt = (bitn == '0) ? 1'b1 : ~shreg[0];
      ST_GUARD: begin
        if (is_tx) drive_nxt = (g < G_HALF) && ~shreg[0];
        else       drive_nxt = err_en && rx_par_bad && (g >= G_WSTART) && (g < G_WEND);
      end
      default: drive_nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tc        <= '0;
      bitn      <= '0;
      g         <= '0;
      shreg     <= '0;
      is_tx     <= 1'b0;
      drive_low <= 1'b0;
      tx_done   <= 1'b0;
      tx_err    <= 1'b0;
      rx_end    <= 1'b0;
    end else begin
      drive_low <= drive_nxt;
      tx_done   <= 1'b0;
      rx_end    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (!line_s) begin
            state <= ST_RX_START;
            tc    <= '0;
            is_tx <= 1'b0;
          end else if (tx_req) begin
            state <= ST_TX_BIT;
            tc    <= '0;
            bitn  <= '0;
            shreg <= tx_pattern;
            is_tx <= 1'b1;
          end
        end
        ST_RX_START: if (tick) begin
          if (tc == TC_MID) begin
            tc <= '0;
            if (line_s) state <= ST_IDLE;
            else begin
              state <= ST_RX_BIT;
              bitn  <= BN_D0;
            end
          end else tc <= tc + 1'b1;
        end
        ST_RX_BIT: if (tick) begin
          if (tc == TC_LAST) begin
            tc    <= '0;
            shreg <= {line_s, shreg[NBIT-1:1]};
            if (bitn == BN_PAR) begin
              state <= ST_GUARD;
              g     <= '0;
            end else bitn <= bitn + 1'b1;
          end else tc <= tc + 1'b1;
        end
        ST_TX_BIT: if (tick) begin
          if (bitn == BN_PAR && tc == TC_MID) begin
            state <= ST_GUARD;
            g     <= '0;
          end else if (tc == TC_LAST) begin
            tc   <= '0;
            bitn <= bitn + 1'b1;
            if (bitn != '0) shreg <= {1'b0, shreg[NBIT-1:1]};
            if (bitn == BN_LASTD && !err_en) begin
              tx_done <= 1'b1;
              tx_err  <= 1'b0;
            end
          end else tc <= tc + 1'b1;
        end
        ST_GUARD: if (tick) begin
          g <= g + 1'b1;
          if (is_tx && err_en && g == G_SAMP) begin
            tx_done <= 1'b1;
            tx_err  <= ~line_s;
          end
          if (g == G_LAST) begin
            state <= ST_IDLE;
            if (!is_tx) rx_end <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign tx_ready  = (state == ST_IDLE) && line_s;
  assign line_bits = shreg;
  assign tx_active = is_tx && (state != ST_IDLE);
endmodule

// File: rtl/sc_uart.sv
module sc_uart #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int ERR_TICKS   = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cfg_inverse,
  input  logic              cfg_err_en,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_perr,
  output logic              tx_done,
  output logic              tx_err,
  input  logic              line_in,
  output logic              line_drive_low
);
  logic              line_s;
  logic [DATA_W:0]   tx_pattern;
  logic [DATA_W:0]   line_bits;
  logic [DATA_W-1:0] rx_byte;
  logic              rx_par_bad;
  logic              rx_end;
  logic              tx_active;

  sc_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .din(line_in), .dout(line_s)
  );

  sc_char_codec #(.DATA_W(DATA_W)) codec_i (
    .inverse(cfg_inverse), .tx_byte(tx_data), .tx_line(tx_pattern),
    .rx_line(line_bits), .rx_byte(rx_byte), .rx_par_bad(rx_par_bad)
  );

  sc_frame_ctrl #(.DATA_W(DATA_W), .OVS(OVS), .ERR_TICKS(ERR_TICKS)) ctrl_i (
    .clk(clk), .rst(rst), .tick(tick), .line_s(line_s), .err_en(cfg_err_en),
    .tx_req(tx_valid), .tx_pattern(tx_pattern), .tx_ready(tx_ready),
    .line_bits(line_bits), .rx_par_bad(rx_par_bad), .rx_end(rx_end),
    .tx_done(tx_done), .tx_err(tx_err), .drive_low(line_drive_low),
    .tx_active(tx_active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_perr  <= 1'b0;
    end else if (rx_end) begin
      rx_valid <= 1'b1;
      rx_data  <= rx_byte;
      rx_perr  <= rx_par_bad;
    end else if (rx_ready) begin
      rx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sc_uart_chk.sv
module sc_uart_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_ready,
  input logic              tx_done,
  input logic              tx_err,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              line_drive_low,
  input logic              cfg_err_en,
  input logic              tx_active
);
  // R10
  txready_busy_chk: assert property (@(posedge clk) disable iff (rst)
    line_drive_low |-> !tx_ready);

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> !tx_done);

  // R11
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R6
  quiet_rx_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(tx_active) && !$past(cfg_err_en)) |-> !line_drive_low);

  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_err) |-> tx_done);

  // R7
  done_in_tx_chk: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> $past(tx_active));
endmodule

bind sc_uart sc_uart_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .tx_ready(tx_ready), .tx_done(tx_done),
  .tx_err(tx_err), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .line_drive_low(line_drive_low),
  .cfg_err_en(cfg_err_en), .tx_active(tx_active)
);

// File: tb/sc_uart_tb_top.sv
`timescale 1ns/1ps
module sc_uart_tb_top;
  localparam int DATA_W = 8;
  localparam int OVS    = 8;
  localparam int ERR    = 12;
  localparam int HALF   = OVS / 2;
  localparam int TDIV   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic cfg_inverse = 1'b0, cfg_err_en = 1'b0;
  logic tx_valid = 1'b0, rx_ready = 1'b1;
  logic [7:0] tx_data = '0;
  logic tx_ready, rx_valid, rx_perr, tx_done, tx_err, line_drive_low;
  logic [7:0] rx_data;
  logic card_low = 1'b0;
  logic line_in;
  logic tx_mon = 1'b0;
  int n_chk = 0, n_fail = 0, tick_cnt = 0, tdiv = 0;
  logic [9:0] txq[$];
  logic [8:0] rxq[$];

  always #10 clk = ~clk;
  assign line_in = !(line_drive_low || card_low);

  sc_uart #(.DATA_W(DATA_W), .OVS(OVS), .ERR_TICKS(ERR)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .cfg_inverse(cfg_inverse),
    .cfg_err_en(cfg_err_en), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_perr(rx_perr), .tx_done(tx_done), .tx_err(tx_err),
    .line_in(line_in), .line_drive_low(line_drive_low)
  );

  always @(negedge clk) begin
    if (rst) begin
      tdiv = 0;
      tick = 1'b0;
    end else begin
      tdiv = (tdiv + 1) % TDIV;
      tick = (tdiv == 0);
      if (tick) tick_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  function automatic logic [9:0] exp_frame(input logic [7:0] b, input bit inv);
    logic [9:0] f;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[1+i] = inv ? ~b[7-i] : b[i];
    f[9] = inv ? ~(^b) : (^b);
    return f;
  endfunction

  // Monitor: decodes frames the block sends and compares with the queue
  initial forever begin
    @(negedge clk);
    if (tx_mon && line_drive_low) begin
      logic [9:0] got, exp;
      exp = (txq.size() != 0) ? txq.pop_front() : 10'h3ff;
      wait_ticks(HALF);
      got[0] = line_in;
      for (int k = 1; k < 10; k++) begin
        wait_ticks(OVS);
        got[k] = line_in;
      end
      check(got == exp, cfg_inverse ? "R3" : "R2", "frame bits", got, exp);
      wait_ticks(OVS);
      check(line_drive_low == 1'b0, "R1", "line released after parity", line_drive_low, 0);
      tx_mon = 1'b0;
    end
  end

  // Monitor: received bytes versus expected items
  always @(negedge clk) begin
    if (!rst && rx_valid && rx_ready) begin
      if (rxq.size() == 0) check(1'b0, "R4", "unexpected rx byte", rx_data, -1);
      else begin
        logic [8:0] e;
        e = rxq.pop_front();
        check(rx_data == e[7:0], "R4", "rx data", rx_data, e[7:0]);
        check(rx_perr == e[8], "R4", "rx parity flag", rx_perr, e[8]);
      end
    end
  end

  task automatic send_tx(input logic [7:0] b, input bit card_err);
    int t0, dt, exp_dt;
    txq.push_back(exp_frame(b, cfg_inverse));
    tx_mon = 1'b1;
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = b;
    @(posedge clk);
    while (!tx_ready) @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    while (!line_drive_low) @(negedge clk);
    t0 = tick_cnt;
    exp_dt = cfg_err_en ? (9*OVS + HALF + OVS + ERR/2) : 9*OVS;
    fork
      begin
        if (card_err) begin
          wait_ticks(10*OVS + HALF + 1);
          card_low = 1'b1;
          wait_ticks(ERR - 2);
          card_low = 1'b0;
        end
      end
      begin
        while (!tx_done) @(negedge clk);
        dt = tick_cnt - t0;
        check(dt >= exp_dt - 2 && dt <= exp_dt + 2, cfg_err_en ? "R8" : "R7",
              "tx_done tick offset", dt, exp_dt);
        check(tx_err == (cfg_err_en && card_err), "R8", "tx_err", tx_err,
              int'(cfg_err_en && card_err));
        @(negedge clk);
        check(tx_done == 1'b0, "R13", "tx_done one cycle", tx_done, 0);
      end
    join
    while (tx_mon) @(negedge clk);
    while (!tx_ready) @(negedge clk);
  endtask

  task automatic card_rx(input logic [7:0] b, input bit bad);
    logic [9:0] f;
    int drv, errc, first;
    f = exp_frame(b, cfg_inverse);
    if (bad) f[9] = ~f[9];
    rxq.push_back({bad, b});
    drv = 0;
    for (int k = 0; k < 10; k++) begin
      card_low = ~f[k];
      for (int t = 0; t < OVS; t++) begin
        wait_ticks(1);
        if (line_drive_low) drv++;
      end
      if (k == 5) check(tx_ready == 1'b0, "R10", "tx_ready during rx", tx_ready, 0);
    end
    card_low = 1'b0;
    check(drv == 0, "R10", "block drove line during rx bits", drv, 0);
    errc = 0;
    first = -1;
    for (int t = 0; t < HALF + ERR + OVS; t++) begin
      wait_ticks(1);
      if (line_drive_low) begin
        errc++;
        if (first < 0) first = t;
      end
    end
    if (cfg_err_en && bad) begin
      check(errc >= ERR - 1 && errc <= ERR + 1, "R5", "error pulse length", errc, ERR);
      check(first >= HALF - 1 && first <= HALF + 1, "R5", "error pulse start", first, HALF);
    end else begin
      check(errc == 0, "R6", "no error pulse", errc, 0);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R12 reset state
    check(tx_ready == 1'b1, "R12", "tx_ready after reset", tx_ready, 1);
    check(line_drive_low == 1'b0, "R12", "line released after reset", line_drive_low, 0);
    check(rx_valid == 1'b0, "R12", "rx_valid after reset", rx_valid, 0);
    check(tx_done == 1'b0, "R12", "tx_done after reset", tx_done, 0);

    // R2 R7: direct, no error signalling
    send_tx(8'hA5, 1'b0);
    send_tx(8'h3C, 1'b0);
    // R3 inverse
    cfg_inverse = 1'b1;
    send_tx(8'hA5, 1'b0);
    // R8 error signalling on transmit
    cfg_err_en = 1'b1;
    cfg_inverse = 1'b0;
    send_tx(8'h5A, 1'b0);
    send_tx(8'h5A, 1'b1);
    cfg_inverse = 1'b1;
    send_tx(8'h81, 1'b1);

    // R4 R5 reception with error signalling
    cfg_inverse = 1'b0;
    card_rx(8'hC3, 1'b0);
    card_rx(8'hC3, 1'b1);
    cfg_inverse = 1'b1;
    card_rx(8'h17, 1'b0);
    card_rx(8'h17, 1'b1);
    // R6 error signalling off
    cfg_err_en = 1'b0;
    cfg_inverse = 1'b0;
    card_rx(8'h99, 1'b1);

    // R9 glitch shorter than half a bit
    card_low = 1'b1;
    wait_ticks(1);
    card_low = 1'b0;
    wait_ticks(2*OVS);
    check(rx_valid == 1'b0, "R9", "no char from glitch", rx_valid, 0);
    check(tx_ready == 1'b1, "R9", "idle after glitch", tx_ready, 1);

    // R10 transmit request refused during reception
    fork
      card_rx(8'h4E, 1'b0);
      begin
        wait_ticks(3*OVS);
        tx_valid = 1'b1;
        tx_data = 8'hFF;
        for (int i = 0; i < 4; i++) begin
          @(negedge clk);
          check(tx_ready == 1'b0, "R10", "tx_ready while receiving", tx_ready, 0);
        end
        tx_valid = 1'b0;
      end
    join

    // R11 hold received byte until taken
    rx_ready = 1'b0;
    card_rx(8'h6D, 1'b0);
    check(rx_valid == 1'b1, "R11", "rx_valid held", rx_valid, 1);
    repeat (10) @(negedge clk);
    check(rx_valid == 1'b1 && rx_data == 8'h6D, "R11", "rx byte held", rx_data, 8'h6D);
    rx_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(rx_valid == 1'b0, "R11", "rx_valid cleared after take", rx_valid, 0);

    check(rxq.size() == 0, "R4", "rx items left", rxq.size(), 0);
    check(txq.size() == 0, "R1", "tx items left", txq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule